// File: doc/BRIEF.md
# Flash Erase and Write Command Gate

This block guards every path by which a microcontroller core can erase or program its on-chip flash. Software reaches it through a byte-wide register write port that has four selects: an erase trigger, a page number, a control byte and a key byte. The block turns qualified trigger writes into single-cycle erase strobes for the flash controller. It also drives a program-mode flag that steers the core's external data-move writes into flash.

An erase needs three things. The key byte must hold the unlock value. The matching source register must have been written since the last erase of that kind. The trigger byte must carry the code for that kind of erase. A mass erase also needs the debug port to be enabled. Each arming write is used up by one erase, so a runaway loop cannot erase twice in a row. The program-mode bit clears itself after each byte written to flash. Writes to it are blocked while interrupts are enabled.

Top module: `flash_cmd_gate`

## Requirements
- R1: After reset, `page_erase_o`, `mass_erase_o`, `prog_mode_o` are 0, `page_o` is 0, the key is 0 and neither erase kind is armed.
- R2: A write of 0x55 to select 0 (trigger) while the page is armed and the block is unlocked raises `page_erase_o` for exactly one cycle, the cycle after the write.
- R3: A page erase consumes the page arming; a further 0x55 with no new write to select 1 (page) gives no strobe.
- R4: A write of 0xAA to the trigger while mass erase is armed, `dbg_en_i` is 1 and the block is unlocked raises `mass_erase_o` for exactly one cycle, the cycle after the write.
- R5: A trigger attempt that fails its qualification (for example 0xAA with `dbg_en_i` low) gives no strobe and leaves both armings unchanged.
- R6: A trigger value other than 0x55 or 0xAA gives no strobe and changes no arming.
- R7: The block is unlocked only while bits [7:4] of the last write to select 3 (key) equal 2. While it is locked, no erase strobe fires and `prog_mode_o` is 0.
- R8: `page_o` equals bits [7:2] of the last write to select 1 (pages 0 to 63), and any write to select 1 arms a page erase.
- R9: Bit 0 of a write to select 2 (control) sets the program-write bit. `prog_mode_o` is that bit ANDed with unlock. A cycle with `flash_wr_i` high clears the bit, and this takes priority over a control write in the same cycle.
- R10: While `irq_en_i` is 1, control writes leave the program-write bit unchanged, whether they try to set it or clear it.
- R11: Bit 1 of a control write arms mass erase (0 disarms it). A mass erase consumes the arming, so a repeated 0xAA gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 trigger, 1 page, 2 control, 3 key |
| reg_wdata_i | input | 8 | Register write data |
| irq_en_i | input | 1 | Interrupts enabled; blocks program-write bit writes |
| dbg_en_i | input | 1 | Debug port enabled; required for mass erase |
| flash_wr_i | input | 1 | A byte was written to flash this cycle |
| page_erase_o | output | 1 | One-cycle page erase strobe |
| mass_erase_o | output | 1 | One-cycle mass erase strobe |
| page_o | output | 6 | Latched page number |
| prog_mode_o | output | 1 | Data-move writes go to flash |

## Verification
Directed sequences test the trigger codes in several orders. A repeat after a successful erase separates single-use arming from sticky arming. An unknown code, or a mass attempt with the debug port off, placed before a valid trigger shows that failed attempts keep the arming. Dropping and restoring the key separates the unlock gate from the arming logic. The program-write bit is set and cleared under both interrupt states and alongside flash byte writes. A long random mix then runs against a bench reference model; it favours the two codes and the unlock key so that armed, unarmed and locked cases all occur often.

// File: rtl/fgate_pkg.sv
package fgate_pkg;
  typedef enum logic [1:0] {
    SEL_TRIG = 2'd0,
    SEL_PAGE = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_KEY  = 2'd3
  } fgate_sel_e;

  localparam int unsigned CTRL_PWE_BIT = 0;
  localparam int unsigned CTRL_MEN_BIT = 1;
  localparam int unsigned NUM_KINDS    = 2;
  localparam int unsigned KIND_PAGE    = 0;
  localparam int unsigned KIND_MASS    = 1;
endpackage

// File: rtl/fgate_unlock.sv
module fgate_unlock #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned KEY_W      = 4,
  parameter int unsigned UNLOCK_KEY = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              unlocked_o
);
  localparam int unsigned KEY_LSB = DATA_W - KEY_W;

  logic [KEY_W-1:0] key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       key_q <= '0;
    else if (key_wr_i) key_q <= wdata_i[KEY_LSB +: KEY_W];
  end

  assign unlocked_o = (key_q == KEY_W'(UNLOCK_KEY));

  // R7: unlock state moves only on a key write
  a_r7_key_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_wr_i |=> $stable(unlocked_o));
endmodule

// File: rtl/fgate_erase.sv
module fgate_erase
  import fgate_pkg::*;
#(
  parameter int unsigned     DATA_W    = 8,
  parameter int unsigned     PAGE_W    = 6,
  parameter logic [DATA_W-1:0] PAGE_CODE = 8'h55,
  parameter logic [DATA_W-1:0] MASS_CODE = 8'hAA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_wr_i,
  input  logic              page_wr_i,
  input  logic              ctrl_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              unlocked_i,
  input  logic              dbg_en_i,
  output logic              page_erase_o,
  output logic              mass_erase_o,
  output logic [PAGE_W-1:0] page_o
);
  localparam int unsigned PAGE_LSB = DATA_W - PAGE_W;

  logic [NUM_KINDS-1:0]             arm_q, arm_ld, arm_val, fire, gate_ok, strobe_q;
  logic [NUM_KINDS-1:0][DATA_W-1:0] code;
  logic [PAGE_W-1:0]                page_q;

  assign code[KIND_PAGE]    = PAGE_CODE;
  assign code[KIND_MASS]    = MASS_CODE;
  assign arm_ld[KIND_PAGE]  = page_wr_i;
  assign arm_val[KIND_PAGE] = 1'b1;
  assign arm_ld[KIND_MASS]  = ctrl_wr_i;
  assign arm_val[KIND_MASS] = wdata_i[CTRL_MEN_BIT];
  assign gate_ok[KIND_PAGE] = 1'b1;
  assign gate_ok[KIND_MASS] = dbg_en_i;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    assign fire[k] = trig_wr_i && (wdata_i == code[k]) && arm_q[k] && unlocked_i && gate_ok[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        arm_q[k]    <= 1'b0;
        strobe_q[k] <= 1'b0;
      end else begin
        strobe_q[k] <= fire[k];
        if (arm_ld[k])    arm_q[k] <= arm_val[k];
        else if (fire[k]) arm_q[k] <= 1'b0;
      end
    end

    // R3 R11: a strobe is never followed by another without re-arming
    a_r3_single_use: assert property (@(posedge clk_i) disable iff (!rst_ni)
      strobe_q[k] |-> !arm_q[k] || $past(arm_ld[k]));
    // R5 R6: a trigger that does not fire keeps the arming
    a_r5_arm_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!arm_ld[k] && !fire[k]) |=> $stable(arm_q[k]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        page_q <= '0;
    else if (page_wr_i) page_q <= wdata_i[PAGE_LSB +: PAGE_W];
  end

  assign page_erase_o = strobe_q[KIND_PAGE];
  assign mass_erase_o = strobe_q[KIND_MASS];
  assign page_o       = page_q;

  // R2 R4: strobes last one cycle
  a_r2_page_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_erase_o |=> !page_erase_o);
  a_r4_mass_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mass_erase_o |=> !mass_erase_o);
  // R4: mass strobe needs the debug port in the trigger cycle
  a_r4_mass_needs_dbg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mass_erase_o) |-> $past(dbg_en_i) && $past(trig_wr_i));
  // R7: no strobe unless unlocked in the trigger cycle
  a_r7_erase_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page_erase_o || mass_erase_o) |-> $past(unlocked_i));
  // R8: page number holds between page writes
  a_r8_page_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !page_wr_i |=> $stable(page_o));
endmodule

// File: rtl/fgate_pwe.sv
module fgate_pwe
  import fgate_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              irq_en_i,
  input  logic              flash_wr_i,
  input  logic              unlocked_i,
  output logic              prog_mode_o
);
  logic pwe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     pwe_q <= 1'b0;
    else if (flash_wr_i)             pwe_q <= 1'b0;
    else if (ctrl_wr_i && !irq_en_i) pwe_q <= wdata_i[CTRL_PWE_BIT];
  end

  assign prog_mode_o = pwe_q && unlocked_i;

  // R9: a flash byte write clears the bit
  a_r9_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_wr_i |=> !pwe_q);
  // R10: writes blocked while interrupts are enabled
  a_r10_irq_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i && !flash_wr_i) |=> $stable(pwe_q));
  // R7: locked means no program mode
  a_r7_prog_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_i |-> !prog_mode_o);
endmodule

// File: rtl/flash_cmd_gate.sv
module flash_cmd_gate
  import fgate_pkg::*;
#(
  parameter int unsigned       DATA_W     = 8,
  parameter int unsigned       PAGE_W     = 6,
  parameter int unsigned       KEY_W      = 4,
  parameter int unsigned       UNLOCK_KEY = 2,
  parameter logic [DATA_W-1:0] PAGE_CODE  = 8'h55,
  parameter logic [DATA_W-1:0] MASS_CODE  = 8'hAA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              irq_en_i,
  input  logic              dbg_en_i,
  input  logic              flash_wr_i,
  output logic              page_erase_o,
  output logic              mass_erase_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              prog_mode_o
);
  fgate_sel_e sel;
  logic       trig_wr, page_wr, ctrl_wr, key_wr, unlocked;

  assign sel     = fgate_sel_e'(reg_sel_i);
  assign trig_wr = reg_we_i && (sel == SEL_TRIG);
  assign page_wr = reg_we_i && (sel == SEL_PAGE);
  assign ctrl_wr = reg_we_i && (sel == SEL_CTRL);
  assign key_wr  = reg_we_i && (sel == SEL_KEY);

  fgate_unlock #(
    .DATA_W(DATA_W), .KEY_W(KEY_W), .UNLOCK_KEY(UNLOCK_KEY)
  ) i_unlock (
    .clk_i(clk_i), .rst_ni(rst_ni), .key_wr_i(key_wr),
    .wdata_i(reg_wdata_i), .unlocked_o(unlocked)
  );

  fgate_erase #(
    .DATA_W(DATA_W), .PAGE_W(PAGE_W), .PAGE_CODE(PAGE_CODE), .MASS_CODE(MASS_CODE)
  ) i_erase (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_wr_i(trig_wr), .page_wr_i(page_wr),
    .ctrl_wr_i(ctrl_wr), .wdata_i(reg_wdata_i), .unlocked_i(unlocked),
    .dbg_en_i(dbg_en_i), .page_erase_o(page_erase_o), .mass_erase_o(mass_erase_o),
    .page_o(page_o)
  );

  fgate_pwe #(
    .DATA_W(DATA_W)
  ) i_pwe (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_wr_i(ctrl_wr), .wdata_i(reg_wdata_i),
    .irq_en_i(irq_en_i), .flash_wr_i(flash_wr_i), .unlocked_i(unlocked),
    .prog_mode_o(prog_mode_o)
  );

  // R2 R4: page and mass strobes never coincide
  a_r2_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({page_erase_o, mass_erase_o}));
endmodule

// File: tb/test_flash_cmd_gate.sv
module test_flash_cmd_gate;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       we, irq, dbg, fw;
  logic [1:0] sel;
  logic [7:0] wd;
  logic       pe, me, pm;
  logic [5:0] pg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  logic [3:0] m_key;
  logic       m_parm, m_marm, m_pwe, m_pe, m_me;
  logic [5:0] m_page;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_gate i_flash_cmd_gate (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wd),
    .irq_en_i(irq), .dbg_en_i(dbg), .flash_wr_i(fw),
    .page_erase_o(pe), .mass_erase_o(me), .page_o(pg), .prog_mode_o(pm)
  );

  function automatic logic f_page_fire(logic w, logic [1:0] s, logic [7:0] d,
                                       logic arm, logic [3:0] key);
    return w && s == 2'd0 && d == 8'h55 && arm && key == 4'd2;
  endfunction

  function automatic logic f_mass_fire(logic w, logic [1:0] s, logic [7:0] d,
                                       logic arm, logic [3:0] key, logic dg);
    return w && s == 2'd0 && d == 8'hAA && arm && key == 4'd2 && dg;
  endfunction

  function automatic logic f_pwe_next(logic cur, logic w, logic [1:0] s,
                                      logic [7:0] d, logic ie, logic f);
    if (f) return 1'b0;
    if (w && s == 2'd2 && !ie) return d[0];
    return cur;
  endfunction

  task automatic model_reset();
    m_key = '0; m_parm = 0; m_marm = 0; m_pwe = 0; m_pe = 0; m_me = 0; m_page = '0;
  endtask

  task automatic model_step();
    logic pf, mf;
    pf = f_page_fire(we, sel, wd, m_parm, m_key);
    mf = f_mass_fire(we, sel, wd, m_marm, m_key, dbg);
    m_pe = pf;
    m_me = mf;
    if (we && sel == 2'd1) begin m_parm = 1'b1; m_page = wd[7:2]; end
    else if (pf) m_parm = 1'b0;
    if (we && sel == 2'd2) m_marm = wd[1];
    else if (mf) m_marm = 1'b0;
    m_pwe = f_pwe_next(m_pwe, we, sel, wd, irq, fw);
    if (we && sel == 2'd3) m_key = wd[7:4];
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk(tag, "page_erase", int'(pe), int'(m_pe));
    chk(tag, "mass_erase", int'(me), int'(m_me));
    chk(tag, "page",       int'(pg), int'(m_page));
    chk(tag, "prog_mode",  int'(pm), int'(m_pwe && m_key == 4'd2));
  endtask

  // called at a negedge; returns at the following negedge
  task automatic step(logic w, logic [1:0] s, logic [7:0] d, logic ie, logic dg,
                      logic f, string tag);
    we = w; sel = s; wd = d; irq = ie; dbg = dg; fw = f;
    @(posedge clk);
    model_step();
    @(negedge clk);
    we = 1'b0;
    chk_all(tag);
  endtask

  task automatic idle(string tag);
    step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] pick;
    logic [7:0] dr;
    void'($urandom(32'd4711));
    rst_n = 1'b0; we = 0; sel = 0; wd = 0; irq = 0; dbg = 0; fw = 0;
    model_reset();
    repeat (3) @(negedge clk);
    chk_all("R1_in_reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1_after_reset");

    // page erase path
    step(1, 2'd3, 8'h20, 0, 0, 0, "R7_unlock");
    step(1, 2'd1, 8'h2C, 0, 0, 0, "R8_page_write");
    chk("R8", "page_value", int'(pg), 11);
    step(1, 2'd0, 8'h55, 0, 0, 0, "R2_page_fire");
    chk("R2", "strobe_high", int'(pe), 1);
    idle("R2_one_cycle");
    chk("R2", "strobe_low", int'(pe), 0);
    step(1, 2'd0, 8'h55, 0, 0, 0, "R3_repeat_no_fire");
    chk("R3", "no_strobe", int'(pe), 0);
    step(1, 2'd1, 8'hFC, 0, 0, 0, "R8_page_63");
    step(1, 2'd0, 8'h12, 0, 0, 0, "R6_other_code");
    step(1, 2'd0, 8'hAA, 0, 1, 0, "R6_mass_code_unarmed");
    step(1, 2'd0, 8'h55, 0, 0, 0, "R6_arm_kept");
    chk("R6", "strobe_after_bad_code", int'(pe), 1);

    // mass erase path
    step(1, 2'd2, 8'h02, 0, 0, 0, "R11_mass_arm");
    step(1, 2'd0, 8'hAA, 0, 0, 0, "R5_no_dbg");
    chk("R5", "no_strobe", int'(me), 0);
    step(1, 2'd0, 8'hAA, 0, 1, 0, "R4_mass_fire");
    chk("R4", "strobe_high", int'(me), 1);
    idle("R4_one_cycle");
    step(1, 2'd0, 8'hAA, 0, 1, 0, "R11_consumed");
    chk("R11", "no_strobe", int'(me), 0);
    step(1, 2'd2, 8'h02, 0, 0, 0, "R11_rearm");
    step(1, 2'd2, 8'h00, 0, 0, 0, "R11_disarm");
    step(1, 2'd0, 8'hAA, 0, 1, 0, "R11_disarmed_no_fire");

    // unlock gate
    step(1, 2'd3, 8'h30, 0, 0, 0, "R7_lock");
    step(1, 2'd1, 8'h04, 0, 0, 0, "R7_page_write_locked");
    step(1, 2'd0, 8'h55, 0, 0, 0, "R7_locked_no_fire");
    chk("R7", "locked_no_strobe", int'(pe), 0);
    step(1, 2'd3, 8'h2F, 0, 0, 0, "R7_relock_open");
    step(1, 2'd0, 8'h55, 0, 0, 0, "R7_fire_after_unlock");

    // program write bit
    step(1, 2'd2, 8'h01, 0, 0, 0, "R9_set");
    chk("R9", "prog_on", int'(pm), 1);
    idle("R9_hold");
    step(0, 2'd0, 8'h00, 0, 0, 1, "R9_byte_clears");
    chk("R9", "prog_off", int'(pm), 0);
    step(1, 2'd2, 8'h01, 1, 0, 0, "R10_set_blocked");
    chk("R10", "prog_off", int'(pm), 0);
    step(1, 2'd2, 8'h01, 0, 0, 0, "R9_set_again");
    step(1, 2'd2, 8'h00, 1, 0, 0, "R10_clear_blocked");
    chk("R10", "prog_on", int'(pm), 1);
    step(1, 2'd2, 8'h01, 0, 0, 1, "R9_clear_priority");
    step(1, 2'd2, 8'h01, 0, 0, 0, "R9_set_third");
    step(1, 2'd3, 8'h00, 0, 0, 0, "R7_lock_hides_prog");
    chk("R7", "prog_locked", int'(pm), 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      pick = 3'($urandom_range(0, 7));
      dr   = 8'($urandom);
      case (pick)
        3'd0, 3'd1: dr = ($urandom_range(0, 1) == 0) ? 8'h55 : 8'hAA;
        3'd2: dr = 8'h20 | (dr & 8'h0F);
        default: ;
      endcase
      step(($urandom_range(0, 3) != 0),
           (pick < 3'd2) ? 2'd0 : (pick == 3'd2) ? 2'd3 : 2'($urandom_range(0, 3)),
           dr, ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) != 0),
           ($urandom_range(0, 7) == 0), "R2_R4_R9_random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule